// File: doc/BRIEF.md
# Signed-Magnitude Accumulator Adder

This block is the accumulator half of an arithmetic unit that keeps numbers in signed-magnitude form. The accumulator is 38 bits wide: a sign bit, two guard bits above the magnitude (Q, then P), and a 35-bit magnitude. Each operation takes a 36-bit memory word (sign plus 35-bit magnitude) and either loads it, or adds it into the accumulator. The add uses one's-complement arithmetic on the 37-bit field below the sign, with end-around carry. A sticky overflow flag records any change of the P bit caused by an addition.

A controller pulses `start` with an operation code, the operand word and the top magnitude bit of the multiplier-quotient register. The block has two states. ST_IDLE waits for a start, latches the request and moves to ST_EXEC. ST_EXEC raises `done` for exactly one cycle, commits the new accumulator and flag on the closing edge, and returns to ST_IDLE. Besides the six load and add variants, there is a round step and a flag test that reports and clears the overflow. Two combinational outputs support branch decisions: one for a zero accumulator and one for a positive sign.

Top module: `sm_acc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the whole accumulator and the overflow flag and returns the block to idle with `done` low.
- R2: A `start` seen in idle gives a `done` pulse of exactly one cycle in the next cycle. The result is on `acc` and `ovf` in the cycle after `done`. A `start` seen while `done` is high is ignored, and `acc` does not change while idle.
- R3: Opcode 0 (reset-add) loads the operand sign (bit 35) into `acc[37]` and the operand magnitude (bits 34:0) into `acc[34:0]`, and clears Q (`acc[36]`) and P (`acc[35]`). Opcode 1 (reset-subtract) does the same but loads the inverted sign.
- R4: Opcode 2 (add) with equal signs adds the operand magnitude to the 37-bit field `acc[36:0]` modulo 2^37 and keeps the sign.
- R5: When the effective operand sign differs from the accumulator sign, the result field is the absolute difference of field and operand magnitude. The sign flips only when the operand magnitude is strictly larger; an exact cancel keeps the old sign, so a negative zero can result.
- R6: Opcode 3 (subtract) inverts the operand sign before adding, opcode 4 (add-absolute) forces it positive, and opcode 5 (subtract-absolute) forces it negative.
- R7: The overflow flag is set when an addition with equal signs, or one where the sign flips, leaves P different from its value before. A difference that keeps the sign never sets it. Once set, only the flag test and reset clear it.
- R8: Opcode 7 (overflow test) drives `ovf_hit` with the flag value during its `done` cycle and clears the flag. `acc` is unchanged. `ovf_hit` is low in every other cycle.
- R9: Opcode 6 (round) adds 1 to the 37-bit field (modulo 2^37) when `mq_msb` was 1 at start, and leaves the field unchanged otherwise. The sign and the overflow flag are never touched.
- R10: `acc_zero` is high exactly when `acc[36:0]` is zero, whatever the sign. `acc_plus` is high exactly when `acc[37]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken only in idle |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| opnd | input | 36 | Memory operand: bit 35 sign, 34:0 magnitude |
| mq_msb | input | 1 | Top magnitude bit of the MQ register, for rounding |
| done | output | 1 | One-cycle completion pulse |
| acc | output | 38 | Accumulator: sign, Q, P, magnitude |
| ovf | output | 1 | Sticky overflow flag |
| ovf_hit | output | 1 | Flag value reported by the overflow test |
| acc_zero | output | 1 | Non-sign bits of the accumulator are all zero |
| acc_plus | output | 1 | Accumulator sign is positive |

## Verification
The add path is tried with equal signs and with differing signs. The differing-sign cases cover operand smaller than, larger than and equal to the field, which separate the no-carry recomplement path, the end-around-carry path with its sign flip, and the negative-zero result. The subtract and absolute variants are applied to operands of both signs, so that a wrong sign rule shows up as a wrong sign or magnitude. Overflow is provoked by a carry into P and then followed by a difference that clears P, which tells a sticky flag from one recomputed each step. Round is run with the MQ bit set and clear.

// File: rtl/sm_acc_pkg.sv
package sm_acc_pkg;

    typedef enum logic [2:0] {
        OP_RADD   = 3'd0,
        OP_RSUB   = 3'd1,
        OP_ADD    = 3'd2,
        OP_SUB    = 3'd3,
        OP_ADDABS = 3'd4,
        OP_SUBABS = 3'd5,
        OP_ROUND  = 3'd6,
        OP_TSTOVF = 3'd7
    } acc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } acc_state_e;

endpackage

// File: rtl/sm_opnd_cond.sv
// Applies the per-operation sign rule to the memory operand.
module sm_opnd_cond
    import sm_acc_pkg::*;
#(
    parameter int MAG_W = 35
) (
    input  acc_op_e            op,
    input  logic [MAG_W:0]     word,
    output logic               eff_sign,
    output logic [MAG_W-1:0]   eff_mag
);

    logic raw_sign;

    always_comb begin
        raw_sign = word[MAG_W];
        eff_mag  = word[MAG_W-1:0];
        unique case (op)
            OP_RSUB,
            OP_SUB:    eff_sign = ~raw_sign;
            OP_ADDABS: eff_sign = 1'b0;
            OP_SUBABS: eff_sign = 1'b1;
            default:   eff_sign = raw_sign;
        endcase
    end

endmodule

// File: rtl/sm_mag_adder.sv
// One's-complement add of a magnitude into the Q/P/magnitude field,
// with end-around carry and recomplement on the no-carry path.
module sm_mag_adder #(
    parameter int MAG_W = 35
) (
    input  logic                 acc_sign,
    input  logic [MAG_W+1:0]     acc_fld,
    input  logic                 opd_sign,
    input  logic [MAG_W-1:0]     opd_mag,
    output logic                 res_sign,
    output logic [MAG_W+1:0]     res_fld,
    output logic                 p_flip
);

    localparam int FLD_W = MAG_W + 2;
    localparam int P_POS = MAG_W;

    logic               signs_differ;
    logic [FLD_W-1:0]   addend;
    logic [FLD_W:0]     raw_sum;
    logic               watch_p;

    always_comb begin
        signs_differ = acc_sign ^ opd_sign;
        addend       = signs_differ ? ~acc_fld : acc_fld;
        raw_sum      = {1'b0, addend} + {{(FLD_W - MAG_W + 1){1'b0}}, opd_mag};

        if (!signs_differ) begin
            res_fld  = raw_sum[FLD_W-1:0];
            res_sign = acc_sign;
            watch_p  = 1'b1;
        end else if (raw_sum[FLD_W]) begin
            // carry out of the field: end-around carry, sign flips
            res_fld  = raw_sum[FLD_W-1:0] + {{(FLD_W-1){1'b0}}, 1'b1};
            res_sign = ~acc_sign;
            watch_p  = 1'b1;
        end else begin
            // no carry: undo the complement, sign stays
            res_fld  = ~raw_sum[FLD_W-1:0];
            res_sign = acc_sign;
            watch_p  = 1'b0;
        end

        p_flip = watch_p && (res_fld[P_POS] != acc_fld[P_POS]);
    end

endmodule

// File: rtl/sm_acc_unit.sv
module sm_acc_unit
    import sm_acc_pkg::*;
#(
    parameter int MAG_W = 35
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2:0]           op_sel,
    input  logic [MAG_W:0]       opnd,
    input  logic                 mq_msb,
    output logic                 done,
    output logic [MAG_W+2:0]     acc,
    output logic                 ovf,
    output logic                 ovf_hit,
    output logic                 acc_zero,
    output logic                 acc_plus
);

    localparam int FLD_W = MAG_W + 2;
    localparam int ACC_W = MAG_W + 3;
    localparam int OPD_W = MAG_W + 1;

    acc_state_e          state_q, state_nxt;
    acc_op_e             op_q;
    logic [OPD_W-1:0]    opnd_q;
    logic                mq_q;
    logic [ACC_W-1:0]    acc_q, acc_nxt;
    logic                ovf_q, ovf_nxt;

    logic                cur_sign;
    logic [FLD_W-1:0]    cur_fld;
    logic                eff_sign;
    logic [MAG_W-1:0]    eff_mag;
    logic                sum_sign;
    logic [FLD_W-1:0]    sum_fld;
    logic                sum_pflip;

    assign cur_sign = acc_q[ACC_W-1];
    assign cur_fld  = acc_q[FLD_W-1:0];

    sm_opnd_cond #(.MAG_W(MAG_W)) u_cond (
        .op       (op_q),
        .word     (opnd_q),
        .eff_sign (eff_sign),
        .eff_mag  (eff_mag)
    );

    sm_mag_adder #(.MAG_W(MAG_W)) u_add (
        .acc_sign (cur_sign),
        .acc_fld  (cur_fld),
        .opd_sign (eff_sign),
        .opd_mag  (eff_mag),
        .res_sign (sum_sign),
        .res_fld  (sum_fld),
        .p_flip   (sum_pflip)
    );

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nxt = ST_EXEC;
            ST_EXEC: state_nxt = ST_IDLE;
        endcase
    end

    // state and register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RADD;
            opnd_q  <= '0;
            mq_q    <= 1'b0;
            acc_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (state_q == ST_IDLE && start) begin
                op_q   <= acc_op_e'(op_sel);
                opnd_q <= opnd;
                mq_q   <= mq_msb;
            end
            acc_q <= acc_nxt;
            ovf_q <= ovf_nxt;
        end
    end

    // output and result process
    always_comb begin
        done    = 1'b0;
        ovf_hit = 1'b0;
        acc_nxt = acc_q;
        ovf_nxt = ovf_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_EXEC: begin
                done = 1'b1;
                unique case (op_q)
                    OP_RADD,
                    OP_RSUB: acc_nxt = {eff_sign, 2'b00, eff_mag};
                    OP_ADD,
                    OP_SUB,
                    OP_ADDABS,
                    OP_SUBABS: begin
                        acc_nxt = {sum_sign, sum_fld};
                        ovf_nxt = ovf_q | sum_pflip;
                    end
                    OP_ROUND: begin
                        if (mq_q)
                            acc_nxt = {cur_sign, cur_fld + {{(FLD_W-1){1'b0}}, 1'b1}};
                    end
                    OP_TSTOVF: begin
                        ovf_hit = ovf_q;
                        ovf_nxt = 1'b0;
                    end
                endcase
            end
        endcase
    end

    assign acc      = acc_q;
    assign ovf      = ovf_q;
    assign acc_zero = (cur_fld == '0);
    assign acc_plus = ~cur_sign;

endmodule

// File: rtl/sm_acc_unit_chk.sv
module sm_acc_unit_chk
    import sm_acc_pkg::*;
#(
    parameter int MAG_W = 35
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [2:0]         op_sel,
    input logic [MAG_W:0]     opnd,
    input logic               done,
    input logic [MAG_W+2:0]   acc,
    input logic               ovf,
    input logic               ovf_hit,
    input logic [2:0]         cur_op
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (acc == '0 && !ovf && !done));

    // R2
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !done) |=> done);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(acc));

    // R3
    radd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !done && op_sel == 3'(OP_RADD)) |=> ##1
        (acc[MAG_W+2] == $past(opnd[MAG_W], 2) &&
         acc[MAG_W+1:0] == {2'b00, $past(opnd[MAG_W-1:0], 2)}));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(done && cur_op == 3'(OP_TSTOVF))) |=> ovf);

    // R8
    tst_report_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == 3'(OP_TSTOVF)) |-> (ovf_hit == ovf));

    // R8
    tst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == 3'(OP_TSTOVF)) |=> (!ovf && $stable(acc)));

    // R8
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && cur_op == 3'(OP_TSTOVF)) |-> !ovf_hit);

endmodule

bind sm_acc_unit sm_acc_unit_chk #(.MAG_W(MAG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_sel  (op_sel),
    .opnd    (opnd),
    .done    (done),
    .acc     (acc),
    .ovf     (ovf),
    .ovf_hit (ovf_hit),
    .cur_op  (op_q)
);

// File: tb/sm_acc_unit_bench.sv
`timescale 1ns/1ps
module sm_acc_unit_bench;

    localparam int MAG_W = 35;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op_sel = 3'd0;
    logic [35:0]   opnd = '0;
    logic          mq_msb = 1'b0;
    logic          done;
    logic [37:0]   acc;
    logic          ovf;
    logic          ovf_hit;
    logic          acc_zero;
    logic          acc_plus;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic          m_sign = 1'b0;
    logic [36:0]   m_fld  = '0;
    logic          m_ovf  = 1'b0;

    always #4 clk = ~clk;

    sm_acc_unit #(.MAG_W(MAG_W)) u_sm_acc_unit (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .opnd(opnd),
        .mq_msb(mq_msb), .done(done), .acc(acc), .ovf(ovf), .ovf_hit(ovf_hit),
        .acc_zero(acc_zero), .acc_plus(acc_plus)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [36:0] ext(input logic [35:0] w);
        return {2'b00, w[34:0]};
    endfunction

    // reference update for one operation; returns expected flag report
    task automatic model(input logic [2:0] op, input logic [35:0] w,
                         input logic m, output logic hit);
        logic es;
        logic [36:0] mg, nf;
        bit watch;
        hit = 1'b0;
        mg  = ext(w);
        case (op)
            3'd0: begin m_sign = w[35];  m_fld = mg; end
            3'd1: begin m_sign = ~w[35]; m_fld = mg; end
            3'd6: if (m) m_fld = m_fld + 37'd1;
            3'd7: begin hit = m_ovf; m_ovf = 1'b0; end
            default: begin
                es = (op == 3'd2) ? w[35] : (op == 3'd3) ? ~w[35] :
                     (op == 3'd4) ? 1'b0 : 1'b1;
                if (es == m_sign) begin
                    nf = m_fld + mg; watch = 1;
                end else if (mg > m_fld) begin
                    nf = mg - m_fld; m_sign = ~m_sign; watch = 1;
                end else begin
                    nf = m_fld - mg; watch = 0;
                end
                if (watch && nf[35] != m_fld[35]) m_ovf = 1'b1;
                m_fld = nf;
            end
        endcase
    endtask

    task automatic check_state(input string tag);
        chk(acc == {m_sign, m_fld}, tag, "acc", 64'(acc), 64'({m_sign, m_fld}));
        chk(ovf == m_ovf, tag, "ovf", 64'(ovf), 64'(m_ovf));
        chk(acc_zero == (m_fld == 0), "R10", "acc_zero", 64'(acc_zero), 64'(m_fld == 0));
        chk(acc_plus == !m_sign, "R10", "acc_plus", 64'(acc_plus), 64'(!m_sign));
    endtask

    // drive one operation at a falling edge, check done and the result
    task automatic do_op(input logic [2:0] op, input logic [35:0] w,
                         input logic m, input string tag);
        logic hit;
        model(op, w, m, hit);
        op_sel = op; opnd = w; mq_msb = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R2", "done pulse", 64'(done), 64'd1);
        chk(ovf_hit == hit, (op == 3'd7) ? "R8" : tag, "ovf_hit", 64'(ovf_hit), 64'(hit));
        @(negedge clk);
        chk(done == 1'b0, "R2", "done low after", 64'(done), 64'd0);
        check_state(tag);
    endtask

    function automatic logic [35:0] wd(input logic s, input longint mag);
        return {s, mag[34:0]};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_sign = 0; m_fld = '0; m_ovf = 0;
        chk(acc == '0 && !ovf, "R1", "reset state", 64'(acc), 64'd0);
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_load();
        do_op(3'd0, wd(1'b0, 1234), 0, "R3");
        do_op(3'd0, wd(1'b1, 77), 0, "R3");
        do_op(3'd1, wd(1'b1, 500), 0, "R3");
        do_op(3'd1, wd(1'b0, 9), 0, "R3");
    endtask

    task automatic t_same_sign();
        do_op(3'd0, wd(1'b0, 100), 0, "R4");
        do_op(3'd2, wd(1'b0, 23), 0, "R4");
        do_op(3'd0, wd(1'b1, 40), 0, "R4");
        do_op(3'd2, wd(1'b1, 2), 0, "R4");
    endtask

    task automatic t_diff();
        do_op(3'd0, wd(1'b0, 5), 0, "R5");
        do_op(3'd2, wd(1'b1, 3), 0, "R5");   // smaller: +2
        do_op(3'd2, wd(1'b1, 7), 0, "R5");   // larger: -5
        do_op(3'd2, wd(1'b0, 5), 0, "R5");   // cancel: -0
        chk(acc_zero && !acc_plus, "R10", "negative zero", 64'(acc), 64'({1'b1, 37'd0}));
    endtask

    task automatic t_variants();
        do_op(3'd0, wd(1'b0, 50), 0, "R6");
        do_op(3'd3, wd(1'b0, 20), 0, "R6");  // 30
        do_op(3'd3, wd(1'b1, 5), 0, "R6");   // 35
        do_op(3'd4, wd(1'b1, 10), 0, "R6");  // 45
        do_op(3'd5, wd(1'b0, 60), 0, "R6");  // -15
        do_op(3'd5, wd(1'b0, 1), 0, "R6");   // -16
    endtask

    task automatic t_overflow();
        do_op(3'd0, wd(1'b0, 64'h7_FFFF_FFFF), 0, "R7");
        do_op(3'd2, wd(1'b0, 1), 0, "R7");   // P sets: overflow
        do_op(3'd2, wd(1'b1, 1), 0, "R7");   // P clears, no flag change
        do_op(3'd0, wd(1'b0, 3), 0, "R7");   // load keeps flag
        do_op(3'd6, wd(1'b0, 0), 1, "R7");
        do_op(3'd7, wd(1'b0, 0), 0, "R8");
        do_op(3'd7, wd(1'b0, 0), 0, "R8");
        // sign-flip path with P change: field 2, operand 2^35+... not reachable via
        // operand alone; use carry into P from negative side instead
        do_op(3'd0, wd(1'b1, 64'h7_FFFF_FFFF), 0, "R7");
        do_op(3'd5, wd(1'b0, 64'h7_FFFF_FFFF), 0, "R7");
        do_op(3'd7, wd(1'b0, 0), 0, "R8");
    endtask

    task automatic t_round();
        do_op(3'd0, wd(1'b1, 41), 0, "R9");
        do_op(3'd6, wd(1'b0, 0), 1, "R9");
        do_op(3'd6, wd(1'b0, 0), 0, "R9");
    endtask

    task automatic t_start_hold();
        logic hit;
        do_op(3'd0, wd(1'b0, 10), 0, "R2");
        model(3'd2, wd(1'b0, 6), 0, hit);
        op_sel = 3'd2; opnd = wd(1'b0, 6); start = 1'b1;
        @(negedge clk);
        chk(done == 1'b1, "R2", "held start done", 64'(done), 64'd1);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2", "held start ignored", 64'(done), 64'd0);
        check_state("R2");
        @(negedge clk);
        check_state("R2");
    endtask

    task automatic t_reset_mid();
        do_op(3'd0, wd(1'b1, 999), 0, "R1");
        do_op(3'd2, wd(1'b1, 64'h7_FFFF_FFFF), 0, "R1");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_sign = 0; m_fld = '0; m_ovf = 0;
        check_state("R1");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_same_sign();
        t_diff();
        t_variants();
        t_overflow();
        t_round();
        t_start_hold();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule